// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs the digital side of an 8-bit successive-approximation converter. A start request carries a 3-bit channel number and a flag that picks single-ended or differential input. The block captures both at the start and drives the analog multiplexer select lines from the captured copy. It then offers a trial code to an external DAC and comparator, one bit position per cycle, beginning at the most significant bit. It reads back a single comparator bit at the end of each trial and builds the answer in its approximation register.

When the block has no conversion in progress, it switches off the converter core and the enable of the core's conversion clock. A start powers the core up for one settle cycle. Eight compare cycles follow, then a single cycle in which the finished code is presented with a done strobe. The core powers down on the cycle after that. The output code register keeps its value until the next conversion completes.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset, core_en_o, conv_clk_en_o, busy_o and done_o are 0, and trial_o, result_o, mux_sel_o and mux_diff_o are all zero.
- R2: A start_i sampled high while idle makes the next cycle a settle cycle. In that cycle core_en_o, conv_clk_en_o and busy_o are 1 and trial_o is 0. The settle cycle lasts exactly one clock.
- R3: The eight cycles after the settle cycle are compare cycles for bit 7 down to bit 0, in that order. In the compare cycle for bit k, trial_o holds the bits already decided above k, has bit k set to 1, and has every bit below k at 0.
- R4: At the end of the compare cycle for bit k, bit k is kept at 1 when cmp_i is 1 (input at or above the trial level) and cleared otherwise. With an ideal comparator, result_o equals the input level.
- R5: done_o is high for exactly one cycle, the tenth cycle after the edge that accepted the start. result_o carries the new code in that same cycle.
- R6: core_en_o and conv_clk_en_o fall on the cycle right after done_o. They are both 0 whenever no conversion is in progress.
- R7: A start_i that is high during the settle, compare or done cycles is ignored. Timing, result and multiplexer outputs stay as if it were absent.
- R8: mux_sel_o and mux_diff_o take chan_i and diff_i (diff_i=1 means differential) at the accepting edge. They hold those values through the conversion and until the next accepted start.
- R9: result_o changes only in the done cycle. It keeps the previous code while idle and throughout a following conversion.
- R10: core_en_o, conv_clk_en_o and busy_o are equal in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Conversion request, taken only when idle |
| chan_i | input | 3 | Channel number for the request |
| diff_i | input | 1 | 1 = differential input, 0 = single-ended |
| cmp_i | input | 1 | Comparator result: 1 when input is at or above trial level |
| trial_o | output | 8 | Trial code to the DAC |
| mux_sel_o | output | 3 | Captured channel select to the analog multiplexer |
| mux_diff_o | output | 1 | Captured input-mode select |
| core_en_o | output | 1 | Converter core power enable |
| conv_clk_en_o | output | 1 | Enable for the core's conversion clock gate |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion strobe |
| result_o | output | 8 | Last completed conversion code |

## Verification
A wrong bit decision in the approximation register shows at trial_o in the very next compare cycle as an unexpected prefix. It also shows in result_o at the done cycle as a code that differs from the modelled input level. A wrong sequencer state shows within one cycle as a misplaced done strobe, a power enable that stays high or drops early, or a trial code whose set bit is in the wrong place. Wrongly captured or drifting multiplexer selects steer the bench's analog model to another channel, so the converted code changes at the done cycle.

// File: rtl/sar_conv_pkg.sv
package sar_conv_pkg;
    typedef enum logic [1:0] {
        CONV_IDLE   = 2'd0,
        CONV_SETTLE = 2'd1,
        CONV_CMP    = 2'd2,
        CONV_DONE   = 2'd3
    } conv_state_e;
endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
    import sar_conv_pkg::*;
#(
    parameter int RES_W = 8,
    parameter int IDX_W = $clog2(RES_W)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    output conv_state_e      state_o,
    output logic [IDX_W-1:0] bit_idx_o,
    output logic             accept_o,
    output logic             last_cmp_o
);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(RES_W - 1);

    typedef struct packed {
        conv_state_e      state;
        logic [IDX_W-1:0] idx;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d    = seq_q;
        accept_o = (seq_q.state == CONV_IDLE) && start_i;
        unique case (seq_q.state)
            CONV_IDLE: begin
                if (start_i) seq_d.state = CONV_SETTLE;
            end
            CONV_SETTLE: begin
                seq_d.state = CONV_CMP;
                seq_d.idx   = TOP_IDX;
            end
            CONV_CMP: begin
                if (seq_q.idx == '0) seq_d.state = CONV_DONE;
                else                 seq_d.idx   = seq_q.idx - IDX_W'(1);
            end
            CONV_DONE: begin
                seq_d.state = CONV_IDLE;
            end
            default: seq_d.state = CONV_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            seq_q.state <= CONV_IDLE;
            seq_q.idx   <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state_o    = seq_q.state;
    assign bit_idx_o  = seq_q.idx;
    assign last_cmp_o = (seq_q.state == CONV_CMP) && (seq_q.idx == '0);

    // R2: an accepted start leads straight into the settle cycle
    p_settle_after_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_q.state == CONV_IDLE && start_i) |=> (seq_q.state == CONV_SETTLE));

    // R2, R3: settle lasts one cycle, then the MSB compare begins
    p_settle_one_cycle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_q.state == CONV_SETTLE) |=> (seq_q.state == CONV_CMP && seq_q.idx == TOP_IDX));

    // R7: a request while busy never restarts the sequence
    p_busy_start_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_q.state != CONV_IDLE && start_i) |=> (seq_q.state != CONV_SETTLE));
endmodule

// File: rtl/sar_search_reg.sv
module sar_search_reg #(
    parameter int RES_W = 8,
    parameter int IDX_W = $clog2(RES_W)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clear_i,
    input  logic             cmp_phase_i,
    input  logic [IDX_W-1:0] bit_idx_i,
    input  logic             last_i,
    input  logic             cmp_i,
    output logic [RES_W-1:0] trial_o,
    output logic [RES_W-1:0] result_o
);
    typedef struct packed {
        logic [RES_W-1:0] sar;
        logic [RES_W-1:0] result;
    } search_t;

    search_t srch_d, srch_q;
    logic [RES_W-1:0] probe;
    logic [RES_W-1:0] below_mask;
    logic [RES_W-1:0] sar_next;

    always_comb begin
        probe      = RES_W'(1) << bit_idx_i;
        below_mask = probe - RES_W'(1);
        sar_next   = cmp_i ? (srch_q.sar | probe) : (srch_q.sar & ~probe);
        trial_o    = cmp_phase_i ? (srch_q.sar | probe) : '0;
        srch_d     = srch_q;
        if (clear_i) begin
            srch_d.sar = '0;
        end else if (cmp_phase_i) begin
            srch_d.sar = sar_next;
            if (last_i) srch_d.result = sar_next;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            srch_q <= '0;
        end else begin
            srch_q <= srch_d;
        end
    end

    assign result_o = srch_q.result;

    // R3: the bit under test is set and nothing below it is
    p_trial_shape_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmp_phase_i |-> (trial_o[bit_idx_i] && ((trial_o & below_mask) == '0)));

    // R4: the decision of this cycle appears in the register next cycle
    p_bit_decision_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmp_phase_i && !clear_i) |=> (srch_q.sar[$past(bit_idx_i)] == $past(cmp_i)));
endmodule

// File: rtl/sar_mux_latch.sv
module sar_mux_latch #(
    parameter int CH_W = 3
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            load_i,
    input  logic [CH_W-1:0] chan_i,
    input  logic            diff_i,
    output logic [CH_W-1:0] sel_o,
    output logic            diff_o
);
    typedef struct packed {
        logic [CH_W-1:0] chan;
        logic            diff;
    } mux_t;

    mux_t mux_d, mux_q;

    always_comb begin
        mux_d = mux_q;
        if (load_i) begin
            mux_d.chan = chan_i;
            mux_d.diff = diff_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            mux_q <= '0;
        end else begin
            mux_q <= mux_d;
        end
    end

    assign sel_o  = mux_q.chan;
    assign diff_o = mux_q.diff;
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
    import sar_conv_pkg::*;
#(
    parameter int RES_W = 8,
    parameter int CH_W  = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [CH_W-1:0]  chan_i,
    input  logic             diff_i,
    input  logic             cmp_i,
    output logic [RES_W-1:0] trial_o,
    output logic [CH_W-1:0]  mux_sel_o,
    output logic             mux_diff_o,
    output logic             core_en_o,
    output logic             conv_clk_en_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [RES_W-1:0] result_o
);
    localparam int IDX_W = $clog2(RES_W);

    conv_state_e      state;
    logic [IDX_W-1:0] bit_idx;
    logic             accept;
    logic             last_cmp;
    logic             active;

    sar_seq_ctrl #(.RES_W(RES_W), .IDX_W(IDX_W)) seq_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .start_i    (start_i),
        .state_o    (state),
        .bit_idx_o  (bit_idx),
        .accept_o   (accept),
        .last_cmp_o (last_cmp)
    );

    sar_search_reg #(.RES_W(RES_W), .IDX_W(IDX_W)) search_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .clear_i     (accept),
        .cmp_phase_i (state == CONV_CMP),
        .bit_idx_i   (bit_idx),
        .last_i      (last_cmp),
        .cmp_i       (cmp_i),
        .trial_o     (trial_o),
        .result_o    (result_o)
    );

    sar_mux_latch #(.CH_W(CH_W)) mux_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (accept),
        .chan_i (chan_i),
        .diff_i (diff_i),
        .sel_o  (mux_sel_o),
        .diff_o (mux_diff_o)
    );

    assign active        = (state != CONV_IDLE);
    assign core_en_o     = active;
    assign conv_clk_en_o = active;
    assign busy_o        = active;
    assign done_o        = (state == CONV_DONE);

    // R5: done never lasts two cycles
    p_done_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R6: the core is off in the cycle after done
    p_core_off_after_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> (!core_en_o && !conv_clk_en_o));

    // R6: power drops only right after a done strobe
    p_power_drop_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(core_en_o) |-> $past(done_o));

    // R8: the captured selects stay put while a conversion runs
    p_mux_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (core_en_o && !done_o) |=> $stable({mux_sel_o, mux_diff_o}));

    // R9: the output code moves only in the done cycle
    p_result_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(result_o) |-> done_o);
endmodule

// File: tb/sar_conv_ctrl_tb_top.sv
module sar_conv_ctrl_tb_top;
    localparam int RES_W = 8;
    localparam int CH_W  = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [CH_W-1:0]  chan = '0;
    logic             diff = 1'b0;
    logic             cmp;
    logic [RES_W-1:0] trial;
    logic [CH_W-1:0]  mux_sel;
    logic             mux_diff;
    logic             core_en, clk_en, busy, done;
    logic [RES_W-1:0] result;

    logic [RES_W-1:0] lvl_se [8];
    logic [RES_W-1:0] lvl_df [8];
    logic [RES_W-1:0] sel_level;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;
    logic [RES_W-1:0] prev_result = '0;

    always #2 clk = ~clk;

    // analog model: the selected input compared against the DAC level
    assign sel_level = mux_diff ? lvl_df[mux_sel] : lvl_se[mux_sel];
    assign cmp       = (sel_level >= trial);

    sar_conv_ctrl #(.RES_W(RES_W), .CH_W(CH_W)) dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .start_i       (start),
        .chan_i        (chan),
        .diff_i        (diff),
        .cmp_i         (cmp),
        .trial_o       (trial),
        .mux_sel_o     (mux_sel),
        .mux_diff_o    (mux_diff),
        .core_en_o     (core_en),
        .conv_clk_en_o (clk_en),
        .busy_o        (busy),
        .done_o        (done),
        .result_o      (result)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic power_chk(input bit exp_on, input string req);
        chk(core_en == exp_on, req, "core_en", int'(core_en), int'(exp_on));
        chk(clk_en == exp_on && busy == exp_on, "R10", "clk_en/busy",
            int'({clk_en, busy}), int'({exp_on, exp_on}));
    endtask

    task automatic set_levels(input logic [2:0] ch, input bit df, input logic [7:0] lv);
        for (int i = 0; i < 8; i++) begin
            lvl_se[i] = lv ^ 8'hA5 ^ 8'(i * 17);
            lvl_df[i] = lv ^ 8'h3C ^ 8'(i * 29);
        end
        if (df) lvl_df[ch] = lv;
        else    lvl_se[ch] = lv;
    endtask

    // one conversion; poke drives a foreign request all through it
    task automatic convert(input logic [2:0] ch, input bit df, input logic [7:0] lv,
                           input bit poke);
        logic [7:0] exp_sar;
        logic [7:0] exp_trial;
        set_levels(ch, df, lv);
        start = 1'b1; chan = ch; diff = df;
        @(negedge clk);
        if (poke) begin chan = ~ch; diff = ~df; end
        else start = 1'b0;
        // settle cycle
        power_chk(1'b1, "R2");
        chk(trial == '0, "R2", "settle trial", int'(trial), 0);
        chk(!done, "R2", "settle done", int'(done), 0);
        exp_sar = '0;
        for (int k = 7; k >= 0; k--) begin
            @(negedge clk);
            exp_trial = exp_sar | (8'd1 << k);
            chk(trial == exp_trial, "R3", "trial", int'(trial), int'(exp_trial));
            if (lv >= exp_trial) exp_sar = exp_trial;
            chk(!done, "R5", "early done", int'(done), 0);
            chk(result == prev_result, "R9", "result hold", int'(result), int'(prev_result));
            chk(mux_sel == ch && mux_diff == df, poke ? "R7" : "R8", "mux",
                int'({mux_sel, mux_diff}), int'({ch, df}));
            if (k == 3) power_chk(1'b1, "R6");
        end
        @(negedge clk);
        start = 1'b0;
        chk(done, "R5", "done strobe", int'(done), 1);
        chk(result == lv, poke ? "R7" : "R4", "result", int'(result), int'(lv));
        power_chk(1'b1, "R6");
        @(negedge clk);
        chk(!done, "R5", "done width", int'(done), 0);
        power_chk(1'b0, "R6");
        chk(trial == '0, "R6", "idle trial", int'(trial), 0);
        prev_result = lv;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog all-R actual=timeout expected=finish");
        summary();
    end

    initial begin
        set_levels(3'd0, 1'b0, 8'd0);
        repeat (3) @(negedge clk);
        // R1 reset state
        power_chk(1'b0, "R1");
        chk(!done && trial == '0 && result == '0, "R1", "reset outputs",
            int'({done, trial, result}), 0);
        chk(mux_sel == '0 && !mux_diff, "R1", "reset mux", int'({mux_sel, mux_diff}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        power_chk(1'b0, "R1");

        // R4, R8: every level, rotating channel and mode
        for (int v = 0; v < 256; v++) begin
            convert(3'(v % 8), v[3], 8'(v), 1'b0);
            // R9, R6: idle gap with a changing comparator, output holds
            if (v % 32 == 0) begin
                set_levels(3'(v % 8), v[3], ~8'(v));
                repeat (3) @(negedge clk);
                chk(result == 8'(v), "R9", "idle hold", int'(result), v);
                power_chk(1'b0, "R6");
            end
        end

        // R7: requests during the conversion are ignored
        convert(3'd5, 1'b1, 8'd200, 1'b1);
        convert(3'd2, 1'b0, 8'd0, 1'b1);
        convert(3'd7, 1'b0, 8'd255, 1'b1);
        convert(3'd0, 1'b1, 8'd128, 1'b0);
        convert(3'd1, 1'b1, 8'd127, 1'b0);

        summary();
    end
endmodule